// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address sequence for a four-beat burst into a synchronous memory. A full start address is captured on a rising clock edge when a start strobe is accepted. There are two strobes: one driven by a processor, which counts only while the chip enable is high, and one driven by a memory controller, which loads whether or not the chip enable is high. The same edge also captures the burst order selected on the mode input.

After the start, each edge on which the advance input is high moves the burst one beat forward. The two low address bits follow either a linear order (count up modulo four from the start value) or an interleaved order (start value XOR the beat number). The upper address bits keep the captured value for the whole burst. With no accepted strobe and advance low, the burst is suspended and the address holds. The outputs are the current burst address and the beat index. Both are registered, so they change one edge after the inputs that cause the change.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low at a rising edge, burst_addr and beat_idx become zero, and any strobe seen in that cycle is ignored.
- R2: When proc_strobe and chip_en are both high at an edge, burst_addr takes the value of addr_in after that edge and beat_idx becomes 0.
- R3: When proc_strobe is high, chip_en is low, and ctrl_strobe and advance are low, burst_addr and beat_idx do not change.
- R4: When ctrl_strobe is high at an edge, the start address is loaded whatever the level of chip_en: burst_addr equals addr_in after that edge and beat_idx is 0.
- R5: When both strobes are high in the same cycle, a load always takes place. The processor path is used when chip_en is high and the controller path when it is low.
- R6: A load takes priority over advance: in a load cycle the advance input has no effect, and beat_idx becomes 0.
- R7: With burst_mode = 0 (linear) captured at load, the low two address bits equal (start low bits + beat_idx) modulo 4.
- R8: With burst_mode = 1 (interleaved) captured at load, the low two address bits equal start low bits XOR beat_idx.
- R9: Each edge with advance high and no load raises beat_idx by one modulo 4, so after four advances the burst returns to its start address.
- R10: With no accepted strobe and advance low (suspend), burst_addr and beat_idx hold their values.
- R11: The address bits above the low two keep the loaded value through the whole burst, including when the low bits wrap from 3 to 0 (no carry).
- R12: burst_mode is sampled only at a load. A change of burst_mode in the middle of a burst does not alter the order until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| proc_strobe | input | 1 | Processor start strobe, gated by chip_en |
| ctrl_strobe | input | 1 | Controller start strobe, ungated |
| chip_en | input | 1 | Chip enable that qualifies proc_strobe |
| advance | input | 1 | Step the burst by one beat |
| burst_mode | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | Start address |
| burst_addr | output | ADDR_W | Current burst address |
| beat_idx | output | BEAT_W | Current beat number |

## Verification
Several rules are checked by assertions on every cycle:
- Each kind of load places addr_in on the outputs with beat 0.
- A gated processor strobe and a suspend leave the outputs unchanged.
- The upper address bits do not move between loads.
- The start value recovered from the low bits and the beat stays constant in both orders.

Some behaviours only the bench scenarios can show:
- The exact orders 1-2-3-0 and 2-3-0-1 that follow from given start values.
- The wrap of the beat back to the start address after four advances.
- The low bits rolling over at an all-ones upper address without any carry.
- A burst_mode change in mid-burst having no effect until the next load.

// File: rtl/burst_seq_pkg.sv
// Shared types for the burst address sequencer.
// Assumes: a single bit selects between the two burst orders.
package burst_seq_pkg;
    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_load_ctrl.sv
// Decodes the two start strobes into one load request.
// Assumes: the processor strobe counts only with chip_en high; the
// controller strobe always counts; the processor path wins when both count.
module burst_load_ctrl (
    input  logic proc_strobe,
    input  logic ctrl_strobe,
    input  logic chip_en,
    output logic load_en,
    output logic proc_sel
);
    // Qualify each strobe and merge them into a single load.
    always_comb begin
        proc_sel = proc_strobe & chip_en;
        load_en  = proc_sel | ctrl_strobe;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
// Beat counter for one burst. A clear request restarts it at zero and
// takes priority over a step; a step counts up modulo 2**BEAT_W.
// Assumes: synchronous active-low reset.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [BEAT_W-1:0] beat
);
    // Count beats, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     beat <= '0;
        else if (clear) beat <= '0;
        else if (step)  beat <= beat + 1'b1;
    end

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> beat == '0);
    // R9
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> beat == BEAT_W'($past(beat) + 1'b1));
endmodule

// File: rtl/burst_low_map.sv
// Maps the start low bits and the beat number to the current low
// address bits, in linear (modular add) or interleaved (XOR) order.
// Assumes: purely combinational; the order value is already registered.
module burst_low_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  burst_order_e      order,
    input  logic [BEAT_W-1:0] start_low,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] low
);
    // Select the order function for the current burst.
    always_comb begin
        case (order)
            ORDER_XOR: low = start_low ^ beat;
            default:   low = start_low + beat;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Top of the burst address sequencer. Captures a start address and the
// burst order on an accepted strobe, then steps the low BEAT_W address
// bits on advance, leaving the upper bits unchanged.
// Assumes: ADDR_W > BEAT_W; synchronous active-low reset.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_strobe,
    input  logic              ctrl_strobe,
    input  logic              chip_en,
    input  logic              advance,
    input  logic              burst_mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [BEAT_W-1:0] beat_idx
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic              load_en;
    logic              proc_sel;
    logic [ADDR_W-1:0] start_q;
    burst_order_e      order_q;
    logic [BEAT_W-1:0] low_bits;

    burst_load_ctrl u_load (
        .proc_strobe (proc_strobe),
        .ctrl_strobe (ctrl_strobe),
        .chip_en     (chip_en),
        .load_en     (load_en),
        .proc_sel    (proc_sel)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load_en),
        .step  (advance),
        .beat  (beat_idx)
    );

    // Capture the start address and burst order on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            order_q <= ORDER_LINEAR;
        end else if (load_en) begin
            start_q <= addr_in;
            order_q <= burst_order_e'(burst_mode);
        end
    end

    burst_low_map #(.BEAT_W(BEAT_W)) u_map (
        .order     (order_q),
        .start_low (start_q[BEAT_W-1:0]),
        .beat      (beat_idx),
        .low       (low_bits)
    );

    // Join the held upper bits with the sequenced low bits.
    always_comb begin
        burst_addr = {start_q[ADDR_W-1:BEAT_W], low_bits};
    end

    // R2
    proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe && chip_en) |=> (burst_addr == $past(addr_in)) && (beat_idx == '0));
    // R4
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_strobe |=> (burst_addr == $past(addr_in)) && (beat_idx == '0));
    // R5
    dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe && ctrl_strobe) |-> load_en);
    // R3
    proc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe && !chip_en && !ctrl_strobe && !advance)
        |=> $stable(burst_addr) && $stable(beat_idx));
    // R10
    suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_sel && !ctrl_strobe && !advance) |=> $stable(burst_addr) && $stable(beat_idx));
    // R11
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(burst_addr[ADDR_W-1:BEAT_W]));
    // R8
    xor_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && order_q == ORDER_XOR)
        |=> (burst_addr[BEAT_W-1:0] ^ beat_idx) == $past(burst_addr[BEAT_W-1:0] ^ beat_idx));
    // R7
    lin_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && order_q == ORDER_LINEAR)
        |=> BEAT_W'(burst_addr[BEAT_W-1:0] - beat_idx)
            == BEAT_W'($past(burst_addr[BEAT_W-1:0]) - $past(beat_idx)));

    initial begin
        assert (UPPER_W > 0) else $error("ADDR_W must exceed BEAT_W");
    end
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
    localparam int AW = 20;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          proc_strobe = 1'b0;
    logic          ctrl_strobe = 1'b0;
    logic          chip_en = 1'b0;
    logic          advance = 1'b0;
    logic          burst_mode = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] burst_addr;
    logic [BW-1:0] beat_idx;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic [AW-1:0] exp_addr_q[$];
    logic [BW-1:0] exp_beat_q[$];
    int            due_q[$];
    string         tag_q[$];

    logic [AW-1:0] m_start = '0;
    logic [BW-1:0] m_beat = '0;
    logic          m_order = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW)) u_burst_addr_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .proc_strobe (proc_strobe),
        .ctrl_strobe (ctrl_strobe),
        .chip_en     (chip_en),
        .advance     (advance),
        .burst_mode  (burst_mode),
        .addr_in     (addr_in),
        .burst_addr  (burst_addr),
        .beat_idx    (beat_idx)
    );

    task automatic compare(string tag, logic [AW-1:0] ea, logic [BW-1:0] eb);
        checks++;
        if (burst_addr !== ea || beat_idx !== eb) begin
            fails++;
            $display("FAIL %s: addr=%05h beat=%0d expected addr=%05h beat=%0d",
                     tag, burst_addr, beat_idx, ea, eb);
        end
    endtask

    // Driver: applies one cycle of inputs and queues the expected result.
    task automatic drive(logic p, logic c, logic ce, logic adv, logic mode,
                         logic [AW-1:0] a, string tag);
        logic [BW-1:0] lo;
        @(negedge clk);
        proc_strobe = p; ctrl_strobe = c; chip_en = ce;
        advance = adv; burst_mode = mode; addr_in = a;
        if ((p && ce) || c) begin
            m_start = a; m_beat = '0; m_order = mode;
        end else if (adv) begin
            m_beat = m_beat + 1'b1;
        end
        lo = m_order ? (m_start[BW-1:0] ^ m_beat) : BW'(m_start[BW-1:0] + m_beat);
        exp_addr_q.push_back({m_start[AW-1:BW], lo});
        exp_beat_q.push_back(m_beat);
        due_q.push_back(cyc + 1);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares outputs once the queued item has come due.
    always @(negedge clk) begin
        if (due_q.size() > 0 && due_q[0] <= cyc) begin
            void'(due_q.pop_front());
            compare(tag_q.pop_front(), exp_addr_q.pop_front(), exp_beat_q.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset clears outputs and ignores a strobe.
        @(negedge clk);
        proc_strobe = 1'b1; chip_en = 1'b1; addr_in = 20'hABCDE;
        @(negedge clk);
        compare("R1 reset", '0, '0);
        @(negedge clk);
        compare("R1 reset held", '0, '0);
        proc_strobe = 1'b0; chip_en = 1'b0;
        rst_n = 1'b1;

        // R2 / R7 / R9 / R11: linear burst from low value 1.
        drive(1, 0, 1, 0, 0, 20'h12345, "R2 proc load");
        drive(0, 0, 0, 1, 0, '0, "R7 linear beat1");
        drive(0, 0, 0, 1, 0, '0, "R7 linear beat2");
        drive(0, 0, 0, 1, 0, '0, "R11 linear wrap no carry");
        drive(0, 0, 0, 1, 0, '0, "R9 back to start");
        // R10: suspend.
        drive(0, 0, 1, 0, 0, 20'h0FFFF, "R10 suspend");
        drive(0, 0, 0, 0, 1, '0, "R10 suspend mode toggle");
        drive(0, 0, 0, 1, 0, '0, "R9 resume advance");
        // R3: gated processor strobe.
        drive(1, 0, 0, 0, 0, 20'h55555, "R3 proc gated");
        // R4 / R8: controller load with chip_en low, interleaved from 2.
        drive(0, 1, 0, 0, 1, 20'h0A0A2, "R4 ctrl load chip_en low");
        drive(0, 0, 0, 1, 1, '0, "R8 xor beat1");
        drive(0, 0, 0, 1, 0, '0, "R12 mode change ignored");
        drive(0, 0, 0, 1, 0, '0, "R8 xor beat3");
        drive(0, 0, 0, 1, 0, '0, "R9 xor back to start");
        // R6: load beats advance.
        drive(0, 0, 0, 1, 0, '0, "R9 step");
        drive(1, 0, 1, 1, 0, 20'h33331, "R6 load with advance");
        drive(0, 0, 0, 1, 0, '0, "R7 linear after R6");
        // R5: both strobes, with and without chip_en.
        drive(1, 1, 0, 1, 1, 20'h44443, "R5 both strobes chip_en low");
        drive(0, 0, 0, 1, 0, '0, "R8 xor from 3");
        drive(1, 1, 1, 0, 0, 20'h77770, "R5 both strobes chip_en high");
        drive(0, 0, 0, 1, 0, '0, "R7 linear from 0");
        // R11: all-ones upper bits, low bits wrap without carry.
        drive(0, 1, 1, 0, 0, 20'hFFFFF, "R4 ctrl load all ones");
        drive(0, 0, 0, 1, 0, '0, "R11 wrap at all ones");
        drive(0, 0, 0, 1, 0, '0, "R11 continue");
        drive(0, 0, 0, 0, 0, '0, "R10 final hold");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule